// File: doc/BRIEF.md
# Shared RAM Arbiter with Bounded Waiting

This block decides, cycle by cycle, which of two masters may use one shared RAM: the processor side or a bus slave port that lets outside agents reach the same memory. Each master raises a request, receives a grant, and sees a stall flag while it is waiting. With no contention the requester is granted on the next clock edge. When both compete, the processor is preferred. Neither side can be locked out forever, because each has a programmable limit on how long it can wait.

A 16-bit control word sets the behaviour. It holds a waiting limit for each master, a protection window that keeps the processor in possession for a set number of cycles after it wins, and a switch that turns off the slave port entirely. A hand-over always passes through one idle cycle, so at most one grant changes at any clock edge. Software or a configuration sequencer loads the word through a plain write strobe.

Top module: `ram_arb_top`

## Requirements
- R1: After reset the control word reads 0x8411: slave wait limit 16 in bits 15:11, processor wait limit 16 in bits 10:6, protection window 8 in bits 5:1, slave port enabled in bit 0. Both grants are low.
- R2: When the RAM is idle and only one master requests, that master's grant is high after the next rising edge. The slave is granted only while bit 0 is set.
- R3: When the RAM is idle and both masters request, the processor is granted, unless the slave has already waited its full limit.
- R4: The two grants are never high together, and no clock edge changes both of them.
- R5: Each stall output equals that side's request while its grant is low, and is low otherwise.
- R6: Once the processor is granted with protection window W, it keeps the grant for at least W+1 cycles while it keeps requesting. With the slave already at its limit, the grant lasts exactly W+1 cycles.
- R7: If the slave has waited its limit L while the processor holds the RAM and the window has expired, the processor loses the grant at the next edge and the slave is granted one edge later. A slave that starts waiting after the window has run out is granted L+2 edges after it first requests.
- R8: If the processor has waited its limit L while the slave holds the RAM, the slave loses the grant at the next edge and the processor is granted one edge later (L+2 edges after it first requests).
- R9: While bit 0 is clear, the slave grant is low from the edge that writes the bit, and slave requests do not hold up the processor.
- R10: A holder that drops its request loses the grant at the next edge. A waiting master can then be granted at the edge after.
- R11: A wait count restarts from zero when its side drops the request. A slave that drops its request for one cycle again waits L+2 edges from the new request.
- R12: A write strobe loads the whole 16-bit word at the rising edge, and the read output shows it from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 16 | Control word to load |
| cfg_q | output | 16 | Current control word |
| cpu_req | input | 1 | Processor requests the RAM |
| cpu_gnt | output | 1 | Processor holds the RAM |
| cpu_stall | output | 1 | Processor waits |
| slv_req | input | 1 | Slave port requests the RAM |
| slv_gnt | output | 1 | Slave port holds the RAM |
| slv_stall | output | 1 | Slave port waits |

## Verification
Two functions can fall in the same cycle. The slave can reach its waiting limit while the processor's protection window is still running, and a forced hand-over can be due while the disable bit is written or while the holder drops its request. The bench provokes these cases with small limits, short windows and frequent random rewrites of the control word under randomly held requests. A per-cycle reference model written from the requirements judges every cycle. Directed runs measure the exact hand-over latencies L+2 and W+1.

// File: rtl/ram_arb_pkg.sv
package ram_arb_pkg;

  // Which master currently holds the shared RAM.
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_SLV  = 2'd2
  } owner_e;

  // Next holder of the RAM. Every hand-over passes through OWN_IDLE,
  // so at most one grant changes per edge.
  function automatic owner_e next_owner(
    input owner_e cur,
    input logic   cpu_want,
    input logic   slv_want,
    input logic   slv_urgent,
    input logic   slv_force,
    input logic   cpu_force
  );
    owner_e nxt;
    nxt = cur;
    case (cur)
      OWN_IDLE: begin
        if (slv_urgent)    nxt = OWN_SLV;
        else if (cpu_want) nxt = OWN_CPU;
        else if (slv_want) nxt = OWN_SLV;
        else               nxt = OWN_IDLE;
      end
      OWN_CPU: nxt = (!cpu_want || slv_force) ? OWN_IDLE : OWN_CPU;
      OWN_SLV: nxt = (!slv_want || cpu_force) ? OWN_IDLE : OWN_SLV;
      default: nxt = OWN_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/ram_arb_cfg.sv
module ram_arb_cfg #(
  parameter int                CFG_W   = 16,
  parameter logic [CFG_W-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (we) q <= wdata;
  end

endmodule

// File: rtl/ram_arb_wait.sv
module ram_arb_wait #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             gnt,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             pending,
  output logic             at_limit
);

  // Saturating wait count: cleared when the side is served or gives up.
  function automatic logic [CNT_W-1:0] wait_next(
    input logic             pend,
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] lim
  );
    if (!pend)           return '0;
    else if (cur < lim)  return cur + CNT_W'(1);
    else                 return cur;
  endfunction

  assign pending  = req && !gnt;
  assign at_limit = pending && (count >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= wait_next(pending, count, limit);
  end

endmodule

// File: rtl/ram_arb_window.sv
module ram_arb_window #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter,
  input  logic             hold,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] remain,
  output logic             active
);

  function automatic logic [CNT_W-1:0] remain_next(
    input logic             ent,
    input logic             hld,
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] per
  );
    if (ent)                return per;
    else if (!hld)          return '0;
    else if (cur != '0)     return cur - CNT_W'(1);
    else                    return '0;
  endfunction

  assign active = (remain != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain <= '0;
    else        remain <= remain_next(enter, hold, remain, period);
  end

endmodule

// File: rtl/ram_arb_top.sv
module ram_arb_top #(
  parameter int FLD_W       = 5,
  parameter int RST_SLV_LIM = 16,
  parameter int RST_CPU_LIM = 16,
  parameter int RST_OWN_PER = 8,
  parameter bit RST_SLV_EN  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [3*FLD_W:0]     cfg_wdata,
  output logic [3*FLD_W:0]     cfg_q,
  input  logic                 cpu_req,
  output logic                 cpu_gnt,
  output logic                 cpu_stall,
  input  logic                 slv_req,
  output logic                 slv_gnt,
  output logic                 slv_stall
);
  import ram_arb_pkg::*;

  localparam int CFG_W  = 3*FLD_W + 1;
  localparam int EN_BIT = 0;
  localparam int OP_LSB = 1;
  localparam int CL_LSB = OP_LSB + FLD_W;
  localparam int SL_LSB = CL_LSB + FLD_W;
  localparam logic [CFG_W-1:0] CFG_RST = {FLD_W'(RST_SLV_LIM), FLD_W'(RST_CPU_LIM),
                                          FLD_W'(RST_OWN_PER), RST_SLV_EN};

  // Field extraction kept in functions so the layout lives in one place.
  function automatic logic [FLD_W-1:0] fld_slv_lim(input logic [CFG_W-1:0] c);
    return c[SL_LSB +: FLD_W];
  endfunction
  function automatic logic [FLD_W-1:0] fld_cpu_lim(input logic [CFG_W-1:0] c);
    return c[CL_LSB +: FLD_W];
  endfunction
  function automatic logic [FLD_W-1:0] fld_own_per(input logic [CFG_W-1:0] c);
    return c[OP_LSB +: FLD_W];
  endfunction

  owner_e           owner_q, owner_d;
  logic [FLD_W-1:0] slv_lim, cpu_lim, own_per;
  logic             slv_en;
  logic [FLD_W-1:0] slv_cnt, cpu_cnt, win_left;
  logic             slv_pend, cpu_pend;
  logic             slv_at_lim, cpu_at_lim;
  logic             win_active;
  logic             slv_want, slv_urgent;
  logic             slv_force, cpu_force;
  logic             cpu_enter, cpu_hold;

  ram_arb_cfg #(.CFG_W(CFG_W), .RST_VAL(CFG_RST)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .q     (cfg_q)
  );

  assign slv_lim = fld_slv_lim(cfg_q);
  assign cpu_lim = fld_cpu_lim(cfg_q);
  assign own_per = fld_own_per(cfg_q);
  assign slv_en  = cfg_q[EN_BIT];

  // Grant and stall outputs.
  assign cpu_gnt   = (owner_q == OWN_CPU);
  assign slv_gnt   = (owner_q == OWN_SLV) && slv_en;
  assign cpu_stall = cpu_req && !cpu_gnt;
  assign slv_stall = slv_req && !slv_gnt;

  ram_arb_wait #(.CNT_W(FLD_W)) u_slv_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (slv_req),
    .gnt      (slv_gnt),
    .limit    (slv_lim),
    .count    (slv_cnt),
    .pending  (slv_pend),
    .at_limit (slv_at_lim)
  );

  ram_arb_wait #(.CNT_W(FLD_W)) u_cpu_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (cpu_req),
    .gnt      (cpu_gnt),
    .limit    (cpu_lim),
    .count    (cpu_cnt),
    .pending  (cpu_pend),
    .at_limit (cpu_at_lim)
  );

  // Named arbitration events, also watched by the checker.
  assign slv_want   = slv_req && slv_en;
  assign slv_urgent = slv_want && slv_at_lim;
  assign slv_force  = (owner_q == OWN_CPU) && !win_active && slv_urgent;
  assign cpu_force  = (owner_q == OWN_SLV) && cpu_at_lim;

  assign owner_d   = next_owner(owner_q, cpu_req, slv_want, slv_urgent, slv_force, cpu_force);
  assign cpu_enter = (owner_d == OWN_CPU) && (owner_q != OWN_CPU);
  assign cpu_hold  = (owner_d == OWN_CPU);

  ram_arb_window #(.CNT_W(FLD_W)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .enter  (cpu_enter),
    .hold   (cpu_hold),
    .period (own_per),
    .remain (win_left),
    .active (win_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_IDLE;
    else        owner_q <= owner_d;
  end

endmodule

// File: rtl/ram_arb_chk.sv
module ram_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_req,
  input logic slv_req,
  input logic cpu_gnt,
  input logic slv_gnt,
  input logic slv_en,
  input logic win_active,
  input logic slv_urgent,
  input logic slv_force,
  input logic cpu_force
);

  assert_gnt_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_gnt && slv_gnt));

  assert_single_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cpu_gnt, slv_gnt} ^ $past({cpu_gnt, slv_gnt})) <= 1);

  assert_tie_cpu_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_gnt && !slv_gnt && cpu_req && slv_req && slv_en && !slv_urgent) |=> cpu_gnt);

  assert_window_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_active && cpu_req) |=> cpu_gnt);

  assert_slv_takeover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slv_force |=> !cpu_gnt);

  assert_cpu_takeover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_force |=> !slv_gnt);

  assert_disabled_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !slv_en |-> !slv_gnt);

  assert_cpu_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && !cpu_req) |=> !cpu_gnt);

  assert_slv_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_gnt && !slv_req) |=> !slv_gnt);

endmodule

bind ram_arb_top ram_arb_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_req    (cpu_req),
  .slv_req    (slv_req),
  .cpu_gnt    (cpu_gnt),
  .slv_gnt    (slv_gnt),
  .slv_en     (slv_en),
  .win_active (win_active),
  .slv_urgent (slv_urgent),
  .slv_force  (slv_force),
  .cpu_force  (cpu_force)
);

// File: tb/ram_arb_top_bench.sv
module ram_arb_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_q;
  logic        cpu_req = 1'b0, slv_req = 1'b0;
  logic        cpu_gnt, cpu_stall, slv_gnt, slv_stall;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  // Reference state, built from the requirements.
  int          m_own;   // 0 idle, 1 processor, 2 slave
  int          m_cw, m_sw, m_win;
  logic [15:0] m_cfg;

  always #5 clk = ~clk;

  ram_arb_top u_ram_arb_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .cpu_req(cpu_req), .cpu_gnt(cpu_gnt), .cpu_stall(cpu_stall),
    .slv_req(slv_req), .slv_gnt(slv_gnt), .slv_stall(slv_stall)
  );

  function automatic logic [15:0] mkcfg(int s, int c, int p, int e);
    return 16'(s * 2048 + c * 64 + p * 2 + e);
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    m_own = 0; m_cw = 0; m_sw = 0; m_win = 0; m_cfg = 16'h8411;
  endtask

  task automatic model_step();
    int  slim = int'(m_cfg) / 2048;
    int  clim = (int'(m_cfg) / 64) % 32;
    int  per  = (int'(m_cfg) / 2) % 32;
    bit  en   = m_cfg[0];
    bit  cg   = (m_own == 1);
    bit  sg   = (m_own == 2) && en;
    bit  sp   = slv_req && !sg;
    bit  cp   = cpu_req && !cg;
    bit  surg = slv_req && en && sp && (m_sw >= slim);
    bit  cat  = cp && (m_cw >= clim);
    int  nown;
    case (m_own)
      0:       nown = surg ? 2 : (cpu_req ? 1 : ((slv_req && en) ? 2 : 0));
      1:       nown = (!cpu_req || (m_win == 0 && surg)) ? 0 : 1;
      default: nown = (!slv_req || !en || cat) ? 0 : 2;
    endcase
    if (nown == 1 && m_own != 1) m_win = per;
    else if (nown == 1)          m_win = (m_win > 0) ? m_win - 1 : 0;
    else                         m_win = 0;
    m_sw = !sp ? 0 : ((m_sw < slim) ? m_sw + 1 : m_sw);
    m_cw = !cp ? 0 : ((m_cw < clim) ? m_cw + 1 : m_cw);
    if (cfg_we) m_cfg = cfg_wdata;
    m_own = nown;
  endtask

  task automatic compare(input string tag);
    bit cg = (m_own == 1);
    bit sg = (m_own == 2) && m_cfg[0];
    chk(tag, "cpu_gnt", int'(cpu_gnt), int'(cg));
    chk(tag, "slv_gnt", int'(slv_gnt), int'(sg));
    chk("R5", "cpu_stall", int'(cpu_stall), int'(cpu_req && !cg));
    chk("R5", "slv_stall", int'(slv_stall), int'(slv_req && !sg));
    chk("R12", "cfg_q", int'(cfg_q), int'(m_cfg));
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic write_cfg(input logic [15:0] v);
    cfg_wdata = v; cfg_we = 1'b1;
    tick("R12");
    cfg_we = 1'b0;
    chk("R12", "cfg_q after write", int'(cfg_q), int'(v));
  endtask

  task automatic idle_all();
    cpu_req = 1'b0; slv_req = 1'b0;
    tick("R10"); tick("R10");
  endtask

  task automatic edges_to_gnt(input bit want_cpu, input string tag, output int n);
    n = 0;
    do begin
      tick(tag);
      n++;
    end while (!(want_cpu ? cpu_gnt : slv_gnt) && n < 100);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "cfg_q reset", int'(cfg_q), 16'h8411);
    chk("R1", "cpu_gnt reset", int'(cpu_gnt), 0);
    chk("R1", "slv_gnt reset", int'(slv_gnt), 0);

    // R2 lone requesters
    cpu_req = 1'b1; tick("R2");
    chk("R2", "lone cpu granted", int'(cpu_gnt), 1);
    cpu_req = 1'b0; tick("R10");
    slv_req = 1'b1; tick("R2");
    chk("R2", "lone slave granted", int'(slv_gnt), 1);
    idle_all();

    // R3 simultaneous fresh requests
    cpu_req = 1'b1; slv_req = 1'b1; tick("R3");
    chk("R3", "tie cpu_gnt", int'(cpu_gnt), 1);
    chk("R3", "tie slv_gnt", int'(slv_gnt), 0);
    idle_all();

    // R7 slave wait limit 4, window 2
    write_cfg(mkcfg(4, 3, 2, 1));
    cpu_req = 1'b1; tick("R7");
    slv_req = 1'b1;
    edges_to_gnt(1'b0, "R7", n);
    chk("R7", "slave latency edges", n, 6);
    idle_all();

    // R8 processor wait limit 3
    slv_req = 1'b1; tick("R8");
    cpu_req = 1'b1;
    edges_to_gnt(1'b1, "R8", n);
    chk("R8", "cpu latency edges", n, 5);
    idle_all();

    // R6 window 8, slave limit 1
    write_cfg(mkcfg(1, 16, 8, 1));
    cpu_req = 1'b1; tick("R6");
    n = cpu_gnt ? 1 : 0;
    slv_req = 1'b1;
    for (int i = 0; i < 60; i++) begin
      tick("R6");
      if (!cpu_gnt) break;
      n++;
    end
    chk("R6", "cpu hold cycles", n, 9);
    idle_all();

    // R11 wait count restarts after a dropped request
    write_cfg(mkcfg(3, 16, 0, 1));
    cpu_req = 1'b1; tick("R11");
    slv_req = 1'b1; tick("R11"); tick("R11");
    slv_req = 1'b0; tick("R11");
    slv_req = 1'b1;
    edges_to_gnt(1'b0, "R11", n);
    chk("R11", "slave latency after restart", n, 5);
    idle_all();

    // R10 release hands over through one idle edge
    cpu_req = 1'b1; tick("R10");
    slv_req = 1'b1; cpu_req = 1'b0;
    tick("R10");
    chk("R10", "cpu released", int'(cpu_gnt), 0);
    tick("R10");
    chk("R10", "slave granted after release", int'(slv_gnt), 1);

    // R9 disabling the port while the slave holds the RAM
    write_cfg(mkcfg(3, 16, 0, 0));
    chk("R9", "slv_gnt after disable", int'(slv_gnt), 0);
    chk("R9", "slv_stall after disable", int'(slv_stall), 1);
    for (int i = 0; i < 20; i++) begin
      tick("R9");
      chk("R9", "slave never granted", int'(slv_gnt), 0);
    end
    cpu_req = 1'b1; tick("R9");
    chk("R9", "cpu not held up", int'(cpu_gnt), 1);
    idle_all();
    write_cfg(mkcfg(5, 5, 3, 1));

    // Random phase: R4 R5 R6 R7 R8 R9 against the reference model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 4 == 0) cpu_req = ~cpu_req;
      if ($urandom % 4 == 0) slv_req = ~slv_req;
      if ($urandom % 150 == 0) begin
        cfg_wdata = mkcfg(int'($urandom % 8), int'($urandom % 8), int'($urandom % 6),
                          int'(($urandom % 8) != 0));
        cfg_we = 1'b1;
      end
      tick("R4");
      cfg_we = 1'b0;
      chk("R4", "grants exclusive", int'(cpu_gnt && slv_gnt), 0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule